// File: doc/BRIEF.md
# Next-PC Sequencer with Branch Delay Slots

This block holds the program-counter pair of a 32-bit core whose control transfers take effect one instruction late. It keeps the address of the instruction now executing and the address of the one after it. Each step strobe shifts the pair forward: the old next address becomes the current address, and a freshly computed address fills the next slot. Because of this shift, the instruction right after a jump or branch (the delay slot) always runs before the redirect lands.

The core's decoder supplies a four-bit flow kind together with the raw jump-index field, the raw 16-bit branch displacement and the two register operands. In return the block gives the new pair and a one-cycle link write carrying the return address for call jumps. It also gives a registered flag marking the next instruction as a delay slot, and a cancel pulse. The cancel pulse belongs to "likely" branches: when such a branch is not taken, its delay-slot instruction is dropped.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_o` becomes RESET_VEC, `npc_o` becomes RESET_VEC+4 and `dslot_o` becomes 0.
- R2: At an edge where `step_i` is low, `pc_o`, `npc_o` and `dslot_o` keep their values.
- R3: Kind 0 is sequential. On a step, `pc_o` takes the old `npc_o` and `npc_o` takes the old `npc_o`+4. Codes 3, 8, 9, 10 and 11 are unused and act the same as kind 0.
- R4: Kind 1 (jump) moves `pc_o` to the old `npc_o`. It moves `npc_o` to a value built from three parts: the top 4 bits of the old `pc_o`, then `jidx_i`, then two zero bits.
- R5: Kind 2 (jump and link) redirects exactly as kind 1. During the step cycle it also raises `link_we_o` with `link_idx_o`=31 and `link_data_o`=`pc_o`+8. `link_we_o` stays low for every other kind and whenever `step_i` is low.
- R6: A taken branch moves `pc_o` to the old `npc_o`. It moves `npc_o` to old `pc_o`+4 plus `disp_i`, where `disp_i` is taken as a signed value, shifted left by 2 and sign-extended. Negative displacements count.
- R7: Kinds 4 to 7 are ordinary branches. When one of them is not taken, the step behaves as sequential: `npc_o` becomes the old `npc_o`+4, and `cancel_o` stays low.
- R8: Kinds 4 and 12 are taken when `opa_i` equals `opb_i`. Kinds 5 and 13 are taken when they differ.
- R9: Kinds 6 and 14 are taken when `opa_i` is signed ≤ 0. Kinds 7 and 15 are taken when `opa_i` is signed > 0. Both tests treat 0x80000000 as negative and 0 as not positive.
- R10: Kinds 12 to 15 are likely branches. When one is not taken, `cancel_o` is high during the step cycle, `pc_o` becomes the old `npc_o`+4 and `npc_o` becomes the old `npc_o`+8.
- R11: `dslot_o` becomes 1 after a step that takes a jump or branch, and 0 after any other step. `cancel_o` is low except during a likely branch that is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Advance the PC pair this cycle |
| kind_i | input | 4 | Flow kind of the executing instruction |
| jidx_i | input | 26 | Jump index field |
| disp_i | input | 16 | Branch displacement field |
| opa_i | input | 32 | First register operand |
| opb_i | input | 32 | Second register operand |
| pc_o | output | 32 | Address of the executing instruction |
| npc_o | output | 32 | Address of the following instruction |
| dslot_o | output | 1 | Current instruction sits in a delay slot |
| cancel_o | output | 1 | Drop the delay-slot instruction (likely branch not taken) |
| link_we_o | output | 1 | Return-address write strobe |
| link_idx_o | output | 5 | Register index for the return address |
| link_data_o | output | 32 | Return address |

## Verification
The bench runs every kind against a behavioural model. It aims at the signed-compare edges: a design using unsigned compares would mistake 0x80000000 for positive, and one that treated zero as positive would wrongly take the >0 branch. Negative displacements catch a missing sign extension, because such a design would land far forward instead of backwards. The skip path of likely branches is checked for both the cancel pulse and the +4 offset of the pair; a design that left the delay slot alive would show `pc_o` equal to the old `npc_o`. Jumps are run from a PC whose top nibble is nonzero, so a design that drops the region bits or takes them from the wrong address would produce a wrong target.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic [3:0] {
        FK_SEQ     = 4'd0,
        FK_JMP     = 4'd1,
        FK_CALL    = 4'd2,
        FK_BR_EQ   = 4'd4,
        FK_BR_NE   = 4'd5,
        FK_BR_LEZ  = 4'd6,
        FK_BR_GTZ  = 4'd7,
        FK_BRL_EQ  = 4'd12,
        FK_BRL_NE  = 4'd13,
        FK_BRL_LEZ = 4'd14,
        FK_BRL_GTZ = 4'd15
    } flow_kind_e;

    typedef enum logic [1:0] {
        CMP_EQ  = 2'd0,
        CMP_NE  = 2'd1,
        CMP_LEZ = 2'd2,
        CMP_GTZ = 2'd3
    } cmp_op_e;

    typedef struct packed {
        logic    is_jump;
        logic    is_link;
        logic    is_branch;
        logic    likely;
        cmp_op_e cmp;
    } flow_dec_t;

    localparam int unsigned STEP_BYTES = 4;

    function automatic flow_dec_t decode_flow(input logic [3:0] code);
        flow_dec_t d;
        d = '{is_jump: 1'b0, is_link: 1'b0, is_branch: 1'b0,
              likely: 1'b0, cmp: CMP_EQ};
        case (code)
            FK_JMP:  d.is_jump = 1'b1;
            FK_CALL: begin
                d.is_jump = 1'b1;
                d.is_link = 1'b1;
            end
            FK_BR_EQ, FK_BR_NE, FK_BR_LEZ, FK_BR_GTZ,
            FK_BRL_EQ, FK_BRL_NE, FK_BRL_LEZ, FK_BRL_GTZ: begin
                d.is_branch = 1'b1;
                d.likely    = code[3];
                d.cmp       = cmp_op_e'(code[1:0]);
            end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pcseq_cond.sv
module pcseq_cond
    import pcseq_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  cmp_op_e           op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              hit
);
    logic same;
    logic neg;
    logic zero;

    assign same = (opa == opb);
    assign neg  = opa[DATA_W-1];
    assign zero = (opa == '0);

    always_comb begin
        case (op)
            CMP_EQ:  hit = same;
            CMP_NE:  hit = !same;
            CMP_LEZ: hit = neg || zero;
            CMP_GTZ: hit = !neg && !zero;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
    import pcseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned JIDX_W = 26,
    parameter int unsigned DISP_W = 16
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] npc,
    input  logic [JIDX_W-1:0] jidx,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] jump_tgt,
    output logic [ADDR_W-1:0] br_tgt,
    output logic [ADDR_W-1:0] seq_next,
    output logic [ADDR_W-1:0] skip_pc,
    output logic [ADDR_W-1:0] skip_npc,
    output logic [ADDR_W-1:0] ret_addr
);
    localparam int unsigned RGN_W = ADDR_W - JIDX_W - 2;
    localparam int unsigned EXT_W = ADDR_W - DISP_W - 2;
    localparam logic [ADDR_W-1:0] ONE_STEP = ADDR_W'(STEP_BYTES);
    localparam logic [ADDR_W-1:0] TWO_STEP = ADDR_W'(2 * STEP_BYTES);

    logic [ADDR_W-1:0] disp_bytes;
    logic [ADDR_W-1:0] pc_plus1;

    generate
        if (RGN_W > 0) begin : g_region
            assign jump_tgt = {pc[ADDR_W-1 -: RGN_W], jidx, 2'b00};
        end else begin : g_flat
            assign jump_tgt = {jidx[ADDR_W-3:0], 2'b00};
        end
        if (EXT_W > 0) begin : g_sext
            assign disp_bytes = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
        end else begin : g_nosext
            assign disp_bytes = {disp[ADDR_W-3:0], 2'b00};
        end
    endgenerate

    assign pc_plus1 = pc + ONE_STEP;
    assign br_tgt   = pc_plus1 + disp_bytes;
    assign seq_next = npc + ONE_STEP;
    assign skip_pc  = npc + ONE_STEP;
    assign skip_npc = npc + TWO_STEP;
    assign ret_addr = pc + TWO_STEP;
endmodule

// File: rtl/pcseq_state.sv
module pcseq_state #(
    parameter int unsigned       ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] pc_d,
    input  logic [ADDR_W-1:0] npc_d,
    input  logic              dslot_d,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] npc_q,
    output logic              dslot_q
);
    localparam logic [ADDR_W-1:0] RESET_NEXT = RESET_VEC + ADDR_W'(4);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= RESET_VEC;
            npc_q   <= RESET_NEXT;
            dslot_q <= 1'b0;
        end else if (load) begin
            pc_q    <= pc_d;
            npc_q   <= npc_d;
            dslot_q <= dslot_d;
        end
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 32,
    parameter int unsigned       JIDX_W    = 26,
    parameter int unsigned       DISP_W    = 16,
    parameter int unsigned       REGIDX_W  = 5,
    parameter int unsigned       LINK_REG  = 31,
    parameter logic [ADDR_W-1:0] RESET_VEC = 32'hBFC0_0000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step_i,
    input  logic [3:0]          kind_i,
    input  logic [JIDX_W-1:0]   jidx_i,
    input  logic [DISP_W-1:0]   disp_i,
    input  logic [ADDR_W-1:0]   opa_i,
    input  logic [ADDR_W-1:0]   opb_i,
    output logic [ADDR_W-1:0]   pc_o,
    output logic [ADDR_W-1:0]   npc_o,
    output logic                dslot_o,
    output logic                cancel_o,
    output logic                link_we_o,
    output logic [REGIDX_W-1:0] link_idx_o,
    output logic [ADDR_W-1:0]   link_data_o
);
    flow_dec_t         dec;
    logic              cond_hit;
    logic              redirect;
    logic              skip;
    logic [ADDR_W-1:0] jump_tgt;
    logic [ADDR_W-1:0] br_tgt;
    logic [ADDR_W-1:0] seq_next;
    logic [ADDR_W-1:0] skip_pc;
    logic [ADDR_W-1:0] skip_npc;
    logic [ADDR_W-1:0] ret_addr;
    logic [ADDR_W-1:0] pc_d;
    logic [ADDR_W-1:0] npc_d;

    assign dec = decode_flow(kind_i);

    pcseq_cond #(.DATA_W(ADDR_W)) u_cond (
        .op  (dec.cmp),
        .opa (opa_i),
        .opb (opb_i),
        .hit (cond_hit)
    );

    pcseq_target #(.ADDR_W(ADDR_W), .JIDX_W(JIDX_W), .DISP_W(DISP_W)) u_target (
        .pc       (pc_o),
        .npc      (npc_o),
        .jidx     (jidx_i),
        .disp     (disp_i),
        .jump_tgt (jump_tgt),
        .br_tgt   (br_tgt),
        .seq_next (seq_next),
        .skip_pc  (skip_pc),
        .skip_npc (skip_npc),
        .ret_addr (ret_addr)
    );

    // A taken transfer keeps the delay slot and redirects the slot after it;
    // an untaken likely branch steps over the delay slot.
    assign redirect = dec.is_jump || (dec.is_branch && cond_hit);
    assign skip     = dec.is_branch && dec.likely && !cond_hit;

    always_comb begin
        pc_d  = npc_o;
        npc_d = seq_next;
        if (dec.is_jump) begin
            npc_d = jump_tgt;
        end else if (dec.is_branch && cond_hit) begin
            npc_d = br_tgt;
        end else if (skip) begin
            pc_d  = skip_pc;
            npc_d = skip_npc;
        end
    end

    pcseq_state #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_state (
        .clk     (clk),
        .rst     (rst),
        .load    (step_i),
        .pc_d    (pc_d),
        .npc_d   (npc_d),
        .dslot_d (redirect),
        .pc_q    (pc_o),
        .npc_q   (npc_o),
        .dslot_q (dslot_o)
    );

    assign cancel_o    = step_i && skip;
    assign link_we_o   = step_i && dec.is_link;
    assign link_idx_o  = REGIDX_W'(LINK_REG);
    assign link_data_o = ret_addr;
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
    parameter int unsigned       ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              step_i,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] npc_o,
    input logic              dslot_o,
    input logic              cancel_o,
    input logic              link_we_o,
    input logic [ADDR_W-1:0] link_data_o
);
    AST_RESET_PAIR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc_o == RESET_VEC && npc_o == RESET_VEC + ADDR_W'(4) && !dslot_o)); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> ($stable(pc_o) && $stable(npc_o) && $stable(dslot_o))); // R2
    AST_PAIR_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (step_i && !cancel_o) |=> (pc_o == $past(npc_o))); // R3
    AST_SKIP_SLOT: assert property (@(posedge clk) disable iff (rst)
        (step_i && cancel_o) |=> (pc_o == $past(npc_o) + ADDR_W'(4) && npc_o == $past(npc_o) + ADDR_W'(8))); // R10
    AST_SKIP_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (step_i && cancel_o) |=> !dslot_o); // R11
    AST_LINK_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> (step_i && !cancel_o)); // R5
    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> (link_data_o == pc_o + ADDR_W'(8))); // R5
    AST_LINK_FLAG: assert property (@(posedge clk) disable iff (rst)
        (step_i && link_we_o) |=> dslot_o); // R11
endmodule

bind pc_sequencer pcseq_checker #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_pcseq_checker (
    .clk         (clk),
    .rst         (rst),
    .step_i      (step_i),
    .pc_o        (pc_o),
    .npc_o       (npc_o),
    .dslot_o     (dslot_o),
    .cancel_o    (cancel_o),
    .link_we_o   (link_we_o),
    .link_data_o (link_data_o)
);

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;
    localparam logic [31:0] RV = 32'hBFC0_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_i = 1'b0;
    logic [3:0]  kind_i = 4'd0;
    logic [25:0] jidx_i = '0;
    logic [15:0] disp_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [31:0] pc_o, npc_o, link_data_o;
    logic        dslot_o, cancel_o, link_we_o;
    logic [4:0]  link_idx_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] m_pc, m_npc;
    logic        m_ds;

    always #5 clk = ~clk;

    pc_sequencer i_pc_sequencer (
        .clk(clk), .rst(rst), .step_i(step_i), .kind_i(kind_i),
        .jidx_i(jidx_i), .disp_i(disp_i), .opa_i(opa_i), .opb_i(opb_i),
        .pc_o(pc_o), .npc_o(npc_o), .dslot_o(dslot_o), .cancel_o(cancel_o),
        .link_we_o(link_we_o), .link_idx_o(link_idx_o), .link_data_o(link_data_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk(req, "pc", pc_o, m_pc);
        chk(req, "npc", npc_o, m_npc);
        chk(req, "dslot", {31'd0, dslot_o}, {31'd0, m_ds});
    endtask

    // One instruction slot: drive, check combinational outputs, clock, check state.
    task automatic run(input string req, input bit stp, input int k,
                       input logic [25:0] ji, input logic [15:0] dp,
                       input logic [31:0] a, input logic [31:0] b);
        logic [31:0] e_pc, e_npc, tgt;
        bit e_ds, e_cancel, e_link, taken, is_br, likely;
        int sa;
        @(negedge clk);
        step_i = stp; kind_i = 4'(k); jidx_i = ji; disp_i = dp; opa_i = a; opb_i = b;
        sa = $signed(a);
        is_br = (k >= 4 && k <= 7) || (k >= 12);
        likely = (k >= 12);
        taken = 1'b0;
        case (k % 4)
            0: taken = (a == b);
            1: taken = (a != b);
            2: taken = (sa <= 0);
            default: taken = (sa > 0);
        endcase
        if (!is_br) taken = 1'b0;
        e_pc = m_npc; e_npc = m_npc + 4; e_ds = 1'b0; e_cancel = 1'b0;
        e_link = (k == 2);
        if (k == 1 || k == 2) begin
            e_npc = (m_pc & 32'hF000_0000) | (32'(ji) * 4);
            e_ds = 1'b1;
        end else if (is_br && taken) begin
            tgt = m_pc + 4 + 32'($signed(dp) * 4);
            e_npc = tgt;
            e_ds = 1'b1;
        end else if (is_br && likely) begin
            e_pc = m_npc + 4; e_npc = m_npc + 8; e_cancel = 1'b1;
        end
        #1;
        chk(req, "cancel", {31'd0, cancel_o}, {31'd0, stp && e_cancel});
        chk(req, "link_we", {31'd0, link_we_o}, {31'd0, stp && e_link});
        if (stp && e_link) begin
            chk(req, "link_data", link_data_o, m_pc + 8);
            chk(req, "link_idx", {27'd0, link_idx_o}, 32'd31);
        end
        @(posedge clk);
        #1;
        if (stp) begin
            m_pc = e_pc; m_npc = e_npc; m_ds = e_ds;
        end
        chk_state(req);
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        m_pc = RV; m_npc = RV + 4; m_ds = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk_state("R1");
        @(negedge clk);
        rst = 1'b0;
        run("R2", 0, 1, 26'h3FF_FFFF, 16'h0, 0, 0);            // no step: hold
        run("R3", 1, 0, 0, 0, 0, 0);                             // sequential
        run("R3", 1, 3, 0, 0, 1, 2);                             // unused code
        run("R4", 1, 1, 26'h012_3456, 0, 0, 0);                  // jump keeps 0xB region
        run("R11", 1, 0, 0, 0, 0, 0);                            // delay slot runs, flag set
        run("R5", 1, 2, 26'h000_0040, 0, 0, 0);                  // call
        run("R6", 1, 4, 0, 16'hFFFE, 32'h55, 32'h55);            // beq taken, negative
        run("R7", 1, 5, 0, 16'h0010, 32'h7, 32'h7);              // bne not taken
        run("R9", 1, 6, 0, 16'h0008, 32'h8000_0000, 0);          // blez on most negative
        run("R9", 1, 7, 0, 16'h0008, 32'h0, 0);                  // bgtz on zero: not taken
        run("R9", 1, 7, 0, 16'h7FFF, 32'h7FFF_FFFF, 0);          // bgtz taken, max offset
        run("R10", 1, 14, 0, 16'h0004, 32'h5, 0);                // blezl not taken: skip
        run("R10", 1, 15, 0, 16'h8000, 32'h1, 0);                // bgtzl taken, min offset
        run("R8", 1, 12, 0, 16'h0002, 32'h1, 32'h2);             // beql not taken
        run("R8", 1, 13, 0, 16'h0002, 32'h1, 32'h2);             // bnel taken
        run("R2", 0, 13, 0, 16'h0002, 32'h1, 32'h2);             // idle, cancel low
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            case ($urandom_range(0, 3))
                0: a = 0;
                1: a = 32'h8000_0000;
                default: ;
            endcase
            b = ($urandom_range(0, 1) == 1) ? a : $urandom;
            run("R8", $urandom_range(0, 4) != 0, $urandom_range(0, 15),
                26'($urandom), 16'($urandom), a, b);
        end
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        m_pc = RV; m_npc = RV + 4; m_ds = 1'b0;
        chk_state("R1");
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule